// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the per-transfer datapath of a single DMA channel. It holds the channel's 16-bit current address and 16-bit current count. From these and an 8-bit page value it forms a 24-bit physical bus address. Each accepted transfer-done strobe moves the address forward by one unit and the count back by one. When the count runs out, the block raises a terminal-count pulse. It then either reloads both registers from their base values (auto-initialize) or masks the channel.

A parameter fixes the transfer unit when the channel is built. In byte mode the address counts bytes. In word mode it counts 16-bit words, so the offset sits one bit higher on the bus and the lowest page bit drops out. The page value never advances. The address therefore wraps inside its 64K-byte window, or 128K-byte window in word mode. Programming logic outside the block supplies the base values, the page and the auto-initialize flag. A one-cycle load strobe copies the bases into the working registers and unmasks the channel. A bus handshake elsewhere pulses the transfer-done input once per completed transfer.

The block has no data stream, so every pin is a plain level or strobe. There is no back-pressure. A strobe that arrives while the channel is masked is dropped.

Top module: `dmaeng_chan`

## Requirements
- R1: With UNIT = XFER_BYTE, bus_addr[23:16] equals cfg_page[7:0] and bus_addr[15:0] equals the current address.
- R2: With UNIT = XFER_WORD, bus_addr[23:17] equals cfg_page[7:1] and bus_addr[16:1] equals the current address. bus_addr[0] is 0, and cfg_page[0] has no effect.
- R3: An xfer_done strobe seen on a clock edge while the channel is unmasked and cfg_load is low adds one to the current address and subtracts one from the current count, both modulo 2^16.
- R4: A step from address 0xFFFF gives address 0x0000. The page part of bus_addr is unchanged, so the bus address wraps within its window.
- R5: An xfer_done strobe while chan_masked is 1 changes neither bus_addr nor residue.
- R6: tc is high for exactly one cycle, in the cycle after the strobe that steps the count from 0x0000. A programmed count N gives N+1 accepted transfers up to and including that strobe.
- R7: If cfg_autoinit is 1 at that final strobe, the current address and count reload from cfg_base_addr and cfg_base_cnt, and the channel stays unmasked.
- R8: If cfg_autoinit is 0 at that final strobe, the address and count still step (the count becomes 0xFFFF) and chan_masked becomes 1. Reset leaves chan_masked at 1, and cfg_load clears it.
- R9: residue equals (count + 1) mod 2^16 in byte mode, and twice that value in word mode. It therefore reads 0 once a transfer run without auto-initialize has completed.
- R10: cfg_load copies cfg_base_addr and cfg_base_cnt into the current registers on the next edge, and it takes priority over a strobe on the same edge. Reset clears both registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Copy the base values into the current registers and unmask the channel |
| cfg_base_addr | input | 16 | Base address in transfer units |
| cfg_base_cnt | input | 16 | Base count, which is the number of transfers minus one |
| cfg_page | input | 8 | Page value for the upper bus address bits |
| cfg_autoinit | input | 1 | Reload from the base values at terminal count |
| xfer_done | input | 1 | One transfer completed |
| bus_addr | output | 24 | Physical bus address of the current transfer |
| residue | output | 17 | Bytes left to move |
| tc | output | 1 | Terminal-count pulse |
| chan_masked | output | 1 | Channel is masked and ignores strobes |

## Verification
A corrupted current address appears on bus_addr in the same cycle, because the mapping is combinational. A wrong count shows on residue at once, but it can stay hidden from tc until the run should end, up to 65536 strobes later. Counting strobes against the terminal-count pulse, and reading residue after every strobe, closes that gap. A slip in the mask or reload logic shows one cycle after the final strobe: a following strobe either moves the address or leaves it unchanged, when it should do the opposite.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;
  localparam int unsigned DMAENG_PAGE_W = 8;
  localparam int unsigned DMAENG_OFS_W  = 16;

  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_unit_e;
endpackage

// File: rtl/dmaeng_step.sv
module dmaeng_step #(
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] base_addr_i,
  input  logic [OFS_W-1:0] base_cnt_i,
  input  logic             autoinit_i,
  input  logic             strobe_i,
  output logic [OFS_W-1:0] cur_addr_o,
  output logic [OFS_W-1:0] cur_cnt_o,
  output logic             mask_o,
  output logic             tc_o
);
  localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};
  localparam logic [OFS_W-1:0] ZERO = '0;

  logic accept;
  logic last;

  assign accept = strobe_i && !mask_o && !load_i;
  assign last   = (cur_cnt_o == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr_o <= '0;
      cur_cnt_o  <= '0;
      mask_o     <= 1'b1;
      tc_o       <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (load_i) begin
        cur_addr_o <= base_addr_i;
        cur_cnt_o  <= base_cnt_i;
        mask_o     <= 1'b0;
      end else if (accept) begin
        if (last) begin
          tc_o <= 1'b1;
          if (autoinit_i) begin
            cur_addr_o <= base_addr_i;
            cur_cnt_o  <= base_cnt_i;
          end else begin
            cur_addr_o <= cur_addr_o + ONE;
            cur_cnt_o  <= cur_cnt_o - ONE;
            mask_o     <= 1'b1;
          end
        end else begin
          cur_addr_o <= cur_addr_o + ONE;
          cur_cnt_o  <= cur_cnt_o - ONE;
        end
      end
    end
  end

  // R4: stepping past the top offset lands on zero
  a_r4_offset_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cur_addr_o == {OFS_W{1'b1}}) && !(last && autoinit_i))
      |=> (cur_addr_o == ZERO));

  // R5: a masked channel holds its address and count
  a_r5_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o && !load_i) |=> ($stable(cur_addr_o) && $stable(cur_cnt_o)));

  // R3: an ordinary step moves the count down by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last) |=> (cur_cnt_o == $past(cur_cnt_o) - ONE));
endmodule

// File: rtl/dmaeng_addr_map.sv
module dmaeng_addr_map
  import dmaeng_pkg::*;
#(
  parameter xfer_unit_e  UNIT   = XFER_BYTE,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 16,
  localparam int unsigned BUS_W = PAGE_W + OFS_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [BUS_W-1:0]  bus_o
);
  generate
    if (UNIT == XFER_WORD) begin : g_word
      logic unused_page_lsb;
      assign unused_page_lsb = page_i[0];
      assign bus_o = {page_i[PAGE_W-1:1], ofs_i, 1'b0};
    end else begin : g_byte
      assign bus_o = {page_i, ofs_i};
    end
  endgenerate
endmodule

// File: rtl/dmaeng_residue.sv
module dmaeng_residue
  import dmaeng_pkg::*;
#(
  parameter xfer_unit_e  UNIT  = XFER_BYTE,
  parameter int unsigned OFS_W = 16,
  localparam int unsigned RES_W = OFS_W + 1
) (
  input  logic [OFS_W-1:0] cnt_i,
  output logic [RES_W-1:0] res_o
);
  localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  logic [OFS_W-1:0] units_left;
  assign units_left = cnt_i + ONE;

  generate
    if (UNIT == XFER_WORD) begin : g_word
      assign res_o = {units_left, 1'b0};
    end else begin : g_byte
      assign res_o = {1'b0, units_left};
    end
  endgenerate
endmodule

// File: rtl/dmaeng_chan.sv
module dmaeng_chan
  import dmaeng_pkg::*;
#(
  parameter xfer_unit_e  UNIT   = XFER_BYTE,
  parameter int unsigned PAGE_W = DMAENG_PAGE_W,
  parameter int unsigned OFS_W  = DMAENG_OFS_W,
  localparam int unsigned BUS_W = PAGE_W + OFS_W,
  localparam int unsigned RES_W = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [OFS_W-1:0]  cfg_base_addr,
  input  logic [OFS_W-1:0]  cfg_base_cnt,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_autoinit,
  input  logic              xfer_done,
  output logic [BUS_W-1:0]  bus_addr,
  output logic [RES_W-1:0]  residue,
  output logic              tc,
  output logic              chan_masked
);
  logic [OFS_W-1:0] cur_addr;
  logic [OFS_W-1:0] cur_cnt;

  dmaeng_step #(.OFS_W(OFS_W)) u_step (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (cfg_load),
    .base_addr_i (cfg_base_addr),
    .base_cnt_i  (cfg_base_cnt),
    .autoinit_i  (cfg_autoinit),
    .strobe_i    (xfer_done),
    .cur_addr_o  (cur_addr),
    .cur_cnt_o   (cur_cnt),
    .mask_o      (chan_masked),
    .tc_o        (tc)
  );

  dmaeng_addr_map #(.UNIT(UNIT), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_map (
    .page_i (cfg_page),
    .ofs_i  (cur_addr),
    .bus_o  (bus_addr)
  );

  dmaeng_residue #(.UNIT(UNIT), .OFS_W(OFS_W)) u_res (
    .cnt_i (cur_cnt),
    .res_o (residue)
  );

  // R7: after an auto-initialize terminal count the bases are back in place
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && $past(cfg_autoinit) && !$past(cfg_load))
      |-> (cur_addr == $past(cfg_base_addr) && cur_cnt == $past(cfg_base_cnt)
           && !chan_masked));

  // R8: a terminal count without auto-initialize leaves the channel masked
  a_r8_mask_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !$past(cfg_autoinit)) |-> chan_masked);

  // R9: a completed run reports nothing left to move
  a_r9_residue_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !$past(cfg_autoinit)) |-> (residue == '0));

  // R6: terminal count is a single-cycle pulse
  a_r6_tc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
endmodule

// File: tb/dmaeng_chan_test.sv
`timescale 1ns/1ps
module dmaeng_chan_test;
  import dmaeng_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_base_addr = '0;
  logic [15:0] cfg_base_cnt = '0;
  logic [7:0]  cfg_page = '0;
  logic        cfg_autoinit = 1'b0;
  logic        xfer_done = 1'b0;
  logic [23:0] bus_b, bus_w;
  logic [16:0] res_b, res_w;
  logic        tc_b, tc_w, msk_b, msk_w;

  always #4 clk = ~clk;

  dmaeng_chan #(.UNIT(XFER_BYTE)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base_addr(cfg_base_addr),
    .cfg_base_cnt(cfg_base_cnt), .cfg_page(cfg_page), .cfg_autoinit(cfg_autoinit),
    .xfer_done(xfer_done), .bus_addr(bus_b), .residue(res_b), .tc(tc_b),
    .chan_masked(msk_b));

  dmaeng_chan #(.UNIT(XFER_WORD)) uut_w (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base_addr(cfg_base_addr),
    .cfg_base_cnt(cfg_base_cnt), .cfg_page(cfg_page), .cfg_autoinit(cfg_autoinit),
    .xfer_done(xfer_done), .bus_addr(bus_w), .residue(res_w), .tc(tc_w),
    .chan_masked(msk_w));

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m_addr, m_cnt;
  logic        m_mask;
  logic [47:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_byte(input logic [15:0] a);
    return {cfg_page, a};
  endfunction

  function automatic logic [23:0] exp_word(input logic [15:0] a);
    return {cfg_page[7:1], a, 1'b0};
  endfunction

  task automatic check_residue(input string tag);
    logic [15:0] u;
    u = m_cnt + 16'd1;
    check(res_b == {1'b0, u}, tag, 32'(res_b), 32'({1'b0, u}));
    check(res_w == {u, 1'b0}, tag, 32'(res_w), 32'({u, 1'b0}));
  endtask

  task automatic program_chan(input logic [15:0] a, input logic [15:0] c,
                              input logic [7:0] pg, input bit ai);
    @(negedge clk);
    cfg_base_addr = a;
    cfg_base_cnt  = c;
    cfg_page      = pg;
    cfg_autoinit  = ai;
    cfg_load      = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_addr = a;
    m_cnt  = c;
    m_mask = 1'b0;
  endtask

  // driver: one strobe, expected address pushed to the scoreboard
  task automatic pulse(input string tag, output bit got_tc);
    bit exp_tc;
    @(negedge clk);
    exp_tc = !m_mask && (m_cnt == 16'h0000);
    if (!m_mask) exp_q.push_back({exp_byte(m_addr), exp_word(m_addr)});
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    if (!m_mask) begin
      if (m_cnt == 16'h0000) begin
        if (cfg_autoinit) begin
          m_addr = cfg_base_addr;
          m_cnt  = cfg_base_cnt;
        end else begin
          m_addr = m_addr + 16'd1;
          m_cnt  = 16'hFFFF;
          m_mask = 1'b1;
        end
      end else begin
        m_addr = m_addr + 16'd1;
        m_cnt  = m_cnt - 16'd1;
      end
    end
    #1;
    check(tc_b == exp_tc && tc_w == exp_tc, {tag, " R6 tc"}, 32'({tc_b, tc_w}),
          32'({exp_tc, exp_tc}));
    check(msk_b == m_mask && msk_w == m_mask, {tag, " R8 mask"},
          32'({msk_b, msk_w}), 32'({m_mask, m_mask}));
    check_residue({tag, " R9 residue"});
    got_tc = tc_b;
  endtask

  // monitor: compares the bus address of each accepted strobe
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (xfer_done && exp_q.size() > 0) begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check(bus_b == e[47:24], "R1 R3 R4 byte bus address", 32'(bus_b), 32'(e[47:24]));
        check(bus_w == e[23:0], "R2 R3 R4 word bus address", 32'(bus_w), 32'(e[23:0]));
      end
    end
  end

  task automatic run_to_tc(input string tag, input int expect_n);
    int n;
    bit t;
    n = 0;
    t = 1'b0;
    while (!t && n < 70000) begin
      pulse(tag, t);
      n++;
    end
    check(n == expect_n, {tag, " R6 transfer count"}, 32'(n), 32'(expect_n));
  endtask

  initial begin
    bit t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R8 R10 reset state
    check(msk_b && msk_w, "R8 reset mask", 32'({msk_b, msk_w}), 32'h3);
    check(bus_b == 24'h0 && bus_w == 24'h0, "R10 reset address", 32'(bus_b), 32'h0);
    check(res_b == 17'd1 && res_w == 17'd2, "R9 reset residue", 32'(res_b), 32'h1);

    // R10 load, R4 wrap, R6 count, R8 mask
    program_chan(16'hFFFE, 16'd3, 8'h35, 1'b0);
    #1;
    check(!msk_b && !msk_w, "R8 load unmasks", 32'({msk_b, msk_w}), 32'h0);
    check(bus_b == 24'h35FFFE, "R10 R1 loaded byte address", 32'(bus_b), 32'h35FFFE);
    check(bus_w == 24'h35FFFC, "R10 R2 loaded word address", 32'(bus_w), 32'h35FFFC);
    m_cnt = 16'd3;
    check_residue("R9 loaded residue");
    run_to_tc("wrap run", 4);
    check(bus_b == 24'h350002, "R4 page kept after wrap", 32'(bus_b), 32'h350002);

    // R5 masked strobe ignored
    pulse("masked", t);
    check(bus_b == 24'h350002 && bus_w == 24'h340004, "R5 masked address held",
          32'(bus_b), 32'h350002);

    // R2 page bit 0 has no effect in word mode
    cfg_page = 8'h34;
    #1;
    check(bus_w == 24'h340004, "R2 page bit0 ignored", 32'(bus_w), 32'h340004);
    check(bus_b == 24'h340002, "R1 page bits in byte mode", 32'(bus_b), 32'h340002);

    // R7 auto-initialize
    program_chan(16'h1200, 16'd1, 8'hA7, 1'b1);
    run_to_tc("auto run", 2);
    check(!msk_b && bus_b == 24'hA71200, "R7 reload address", 32'(bus_b), 32'hA71200);
    check(res_b == 17'd2 && res_w == 17'd4, "R7 R9 reload residue", 32'(res_b), 32'h2);
    run_to_tc("auto second run", 2);

    // R6 single transfer with count 0
    program_chan(16'h0040, 16'd0, 8'h01, 1'b0);
    run_to_tc("single run", 1);

    // R10 load has priority over a strobe on the same edge
    program_chan(16'h0100, 16'd9, 8'h02, 1'b0);
    @(negedge clk);
    cfg_base_addr = 16'h0500;
    cfg_base_cnt  = 16'd7;
    cfg_load = 1'b1;
    xfer_done = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    xfer_done = 1'b0;
    #1;
    check(bus_b == 24'h020500 && res_b == 17'd8, "R10 load beats strobe",
          32'(bus_b), 32'h020500);

    // R3 longer run, residue tracked each step
    m_addr = 16'h0500;
    m_cnt = 16'd7;
    m_mask = 1'b0;
    run_to_tc("long run", 8);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog R6 actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule